// File: doc/BRIEF.md
# Double-Buffered Serial Transmitter with Empty Interrupt

This block serializes bytes onto a single output line. A one-byte staging register sits in front of a frame shifter, so software can write the next byte while the current frame is still going out. As soon as the staged byte moves into the shifter, an empty flag rises and, when enabled, an interrupt request asks for the next byte. A byte that is staged while a frame is still being sent follows it with no idle gap.

Three framings are available. The first is a plain asynchronous frame with a start bit, eight data bits and a stop bit. The second adds an address/data marker bit between the last data bit and the stop bit. The third is a bare synchronous burst of eight data bits. Bit timing comes from an external one-cycle tick. Each bit stays on the line for one tick period.

Top module: `sertx_dbuf`

## Requirements
- R1: After reset, `empty` is 1, `txd` is 1 and `irq` is 0 while `irq_en` is 0. `irq` always equals `empty` AND `irq_en`.
- R2: `empty` rises only in the cycle after a tick moves the staged byte into the shifter. With `irq_en` low, `irq` stays 0.
- R3: A write pulse (`wr_en` high for one cycle) stages `wr_data`, and `empty` reads 0 from the next cycle on. A write while the staging register is full replaces the staged byte.
- R4: Modes 2'b00 and 2'b11 send a 10-bit frame: a start bit of 0, then D0 to D7 (LSB first), then a stop bit of 1. `txd` changes only in the cycle after a tick, so each bit lasts exactly one tick period.
- R5: Mode 2'b01 sends a start bit of 0, then D0 to D7, then the `addr_bit` value, then a stop bit of 1 (11 bits).
- R6: Mode 2'b10 sends only D0 to D7, LSB first, with no start bit and no stop bit.
- R7: A byte staged before the last bit of a frame ends has its first bit driven on the tick that ends that last bit, so there is no idle bit between frames.
- R8: When no frame is in progress, `txd` is 1. A byte written to an idle transmitter puts its first bit on the line at the first tick sampled after the write cycle.
- R9: `mode` and `addr_bit` are captured when a byte enters the shifter. Changing them during the frame does not alter that frame.
- R10: When a write and a transfer fall in the same cycle, the shifter takes the old staged byte and the new byte stays staged, so `empty` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the staging register |
| wr_data | input | 8 | Byte to stage |
| mode | input | 2 | Framing select: 00/11 async, 01 async with address bit, 10 synchronous |
| addr_bit | input | 1 | Address/data marker value for mode 01 |
| irq_en | input | 1 | Interrupt enable |
| tick | input | 1 | One-cycle bit-rate tick |
| txd | output | 1 | Serial output line |
| empty | output | 1 | Staging register empty flag |
| irq | output | 1 | Transmit interrupt request |

## Verification
The write path and the transfer path can act on the staging register in the same cycle. A byte written in a cycle where a tick moves the previous byte into the shifter must stay staged, and `empty` must not rise. To provoke this, one phase raises the tick on every cycle and writes bytes in long runs, so writes often land exactly on transfer cycles. A behavioural model applies the transfer first and the write second, and it is compared with `txd`, `empty` and `irq` on every clock. A lost byte or a flag that goes high when it should not shows up as a mismatch in the bit stream or in `empty`.

// File: rtl/sertx_pkg.sv
package sertx_pkg;
  localparam int unsigned DATA_W  = 8;
  localparam int unsigned FRAME_W = DATA_W + 3;
  localparam int unsigned CNT_W   = $clog2(FRAME_W + 1);

  typedef enum logic [1:0] {
    FMT_ASYNC     = 2'b00,
    FMT_ADDR      = 2'b01,
    FMT_SYNC      = 2'b10,
    FMT_ASYNC_ALT = 2'b11
  } fmt_e;
endpackage

// File: rtl/sertx_stage.sv
module sertx_stage #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         take,
  output logic [W-1:0] data,
  output logic         full
);
  logic [W-1:0] data_n;
  logic         full_n;

  always_comb begin
    data_n = data;
    full_n = full;
    if (take)  full_n = 1'b0;
    if (wr_en) begin
      full_n = 1'b1;
      data_n = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      data <= '0;
    end else begin
      full <= full_n;
      if (wr_en) data <= data_n;
    end
  end
endmodule

// File: rtl/sertx_framer.sv
module sertx_framer
  import sertx_pkg::*;
#(
  parameter int unsigned W  = DATA_W,
  parameter int unsigned FW = W + 3,
  parameter int unsigned CW = $clog2(FW + 1)
) (
  input  logic [W-1:0]  data,
  input  logic [1:0]    mode,
  input  logic          addr_bit,
  output logic [FW-1:0] frame,
  output logic [CW-1:0] nbits
);
  always_comb begin
    frame = '1;
    unique case (fmt_e'(mode))
      FMT_ADDR: begin
        frame[0]     = 1'b0;
        frame[W:1]   = data;
        frame[W+1]   = addr_bit;
        nbits        = CW'(W + 3);
      end
      FMT_SYNC: begin
        frame[W-1:0] = data;
        nbits        = CW'(W);
      end
      default: begin
        frame[0]     = 1'b0;
        frame[W:1]   = data;
        nbits        = CW'(W + 2);
      end
    endcase
  end
endmodule

// File: rtl/sertx_shifter.sv
module sertx_shifter #(
  parameter int unsigned FW = 11,
  parameter int unsigned CW = $clog2(FW + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick,
  input  logic          avail,
  input  logic [FW-1:0] frame,
  input  logic [CW-1:0] nbits,
  output logic          take,
  output logic          txd
);
  logic          busy, busy_n;
  logic [FW-1:0] sh, sh_n;
  logic [CW-1:0] left, left_n;
  logic          txd_n;
  logic          more;

  assign more = busy && (left != '0);
  assign take = tick && avail && !more;

  always_comb begin
    busy_n = busy;
    sh_n   = sh;
    left_n = left;
    txd_n  = txd;
    if (tick) begin
      if (more) begin
        txd_n  = sh[0];
        sh_n   = {1'b1, sh[FW-1:1]};
        left_n = left - 1'b1;
      end else if (avail) begin
        txd_n  = frame[0];
        sh_n   = {1'b1, frame[FW-1:1]};
        left_n = nbits - 1'b1;
        busy_n = 1'b1;
      end else begin
        txd_n  = 1'b1;
        busy_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      sh   <= '1;
      left <= '0;
      txd  <= 1'b1;
    end else if (tick) begin
      busy <= busy_n;
      sh   <= sh_n;
      left <= left_n;
      txd  <= txd_n;
    end
  end
endmodule

// File: rtl/sertx_dbuf.sv
module sertx_dbuf
  import sertx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        mode,
  input  logic              addr_bit,
  input  logic              irq_en,
  input  logic              tick,
  output logic              txd,
  output logic              empty,
  output logic              irq
);
  logic [DATA_W-1:0]  st_data;
  logic               st_full;
  logic               take;
  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   nbits;

  sertx_stage #(.W(DATA_W)) i_stage (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .take(take), .data(st_data), .full(st_full)
  );

  sertx_framer #(.W(DATA_W), .FW(FRAME_W), .CW(CNT_W)) i_framer (
    .data(st_data), .mode(mode), .addr_bit(addr_bit),
    .frame(frame), .nbits(nbits)
  );

  sertx_shifter #(.FW(FRAME_W), .CW(CNT_W)) i_shifter (
    .clk(clk), .rst_n(rst_n), .tick(tick), .avail(st_full),
    .frame(frame), .nbits(nbits), .take(take), .txd(txd)
  );

  assign empty = !st_full;
  assign irq   = empty && irq_en;
endmodule

// File: rtl/sertx_dbuf_chk.sv
module sertx_dbuf_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_en,
  input logic tick,
  input logic txd,
  input logic empty
);
  assert_clear_after_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !empty);

  assert_fall_needs_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(empty) |-> $past(wr_en));

  assert_rise_on_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty) |-> $past(tick));

  assert_hold_between_ticks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(tick) |-> $stable(txd));
endmodule

bind sertx_dbuf sertx_dbuf_chk i_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .tick(tick), .txd(txd), .empty(empty)
);

// File: tb/test_sertx_dbuf.sv
module test_sertx_dbuf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [1:0] mode = 2'b00;
  logic       addr_bit = 1'b0;
  logic       irq_en = 1'b0;
  logic       tick = 1'b0;
  logic       txd, empty, irq;

  int compared = 0;
  int mismatched = 0;
  int tper = 4;
  string tag = "R1";

  sertx_dbuf i_sertx_dbuf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .mode(mode),
    .addr_bit(addr_bit), .irq_en(irq_en), .tick(tick), .txd(txd),
    .empty(empty), .irq(irq)
  );

  always #10 clk = ~clk;

  // tick generator: one-cycle pulse every tper cycles
  initial begin
    int cnt = 0;
    forever begin
      @(posedge clk); #2;
      cnt = cnt + 1;
      if (cnt >= tper) begin tick = 1'b1; cnt = 0; end
      else tick = 1'b0;
    end
  end

  // behavioural reference model
  bit       m_hv, m_busy, m_line;
  bit [7:0] m_hd;
  bit       q[$];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_hv = 0; m_busy = 0; m_line = 1; q.delete();
    end else begin
      if (tick) begin
        if (m_busy && q.size() > 0) m_line = q.pop_front();
        else if (m_hv) begin
          q.delete();
          if (mode != 2'b10) q.push_back(1'b0);
          for (int i = 0; i < 8; i++) q.push_back(m_hd[i]);
          if (mode == 2'b01) q.push_back(addr_bit);
          if (mode != 2'b10) q.push_back(1'b1);
          m_line = q.pop_front();
          m_busy = 1; m_hv = 0;
        end else begin
          m_busy = 0; m_line = 1;
        end
      end
      if (wr_en) begin m_hv = 1; m_hd = wr_data; end
    end
  end

  task automatic check(string t, string what, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", t, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    check(tag, "txd", txd, m_line);
    check(tag, "empty", empty, !m_hv);
    check(tag, "irq", irq, (!m_hv) && irq_en);
  end

  task automatic put(input logic [7:0] d);
    @(posedge clk); #2;
    wr_en = 1'b1; wr_data = d;
    @(posedge clk); #2;
    wr_en = 1'b0;
  endtask

  task automatic drain();
    int n = 0;
    while ((m_busy || m_hv) && n < 5000) begin @(posedge clk); n++; end
    repeat (3 * tper + 2) @(posedge clk);
  endtask

  initial begin
    #(20 * 150000);
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2;
    // R1: reset state
    check("R1", "empty", empty, 1);
    check("R1", "txd", txd, 1);
    check("R1", "irq", irq, 0);
    rst_n = 1'b1;
    irq_en = 1'b1;
    repeat (4) @(posedge clk);

    tag = "R4 R8"; mode = 2'b00; put(8'hA5); drain();
    tag = "R4"; mode = 2'b11; put(8'h3C); drain();
    tag = "R5"; mode = 2'b01; addr_bit = 1'b1; put(8'h5A); drain();
    addr_bit = 1'b0; put(8'hF0); drain();
    tag = "R6"; mode = 2'b10; put(8'h96); drain();
    put(8'h01); drain();

    tag = "R7 R2"; mode = 2'b00; irq_en = 1'b0;
    put(8'h11); put(8'h22); drain();
    irq_en = 1'b1; put(8'hC3); put(8'h7E); drain();

    tag = "R9"; mode = 2'b01; addr_bit = 1'b1; tper = 3;
    put(8'h6D);
    repeat (12) @(posedge clk);
    #2; mode = 2'b10; addr_bit = 1'b0;
    drain();
    mode = 2'b00;

    // R10 and R3: tick every cycle, writes collide with transfers
    tag = "R10 R3"; tper = 1;
    for (int k = 0; k < 40; k++) begin
      @(posedge clk); #2;
      wr_en = (k % 7) != 6; wr_data = 8'(k * 37 + 5);
      mode = 2'(k % 3);
    end
    @(posedge clk); #2; wr_en = 1'b0; mode = 2'b00;
    drain();
    tper = 2;
    put(8'hAA); put(8'h55); put(8'h0F); drain();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule